// File: doc/BRIEF.md
# Serial Non-Volatile Memory Program-and-Verify Sequencer

This block turns one request (start address, byte count, direction) into the sequence of serial-memory commands needed to program or read a serial EEPROM or flash part. A lower-level command engine sends each command on the serial pins. The sequencer hands that engine one command at a time: an opcode, an optional address, a byte count of up to 16, and a data vector. The caller's data sits in a byte buffer that the sequencer reads or writes through an index port.

In write mode the request is cut into chunks. No chunk crosses a device write-block boundary, and no chunk is longer than the engine's transfer limit. Each chunk goes through four steps. The sequencer sets the write-enable latch and sends the data. It then polls the status register, waiting a fixed interval before each poll, until the part is no longer busy. Finally it reads the chunk back and compares it with the data it sent. In read mode the request is cut only at the transfer limit. The bytes returned are written into the caller's buffer.

On a small 512-byte part with a one-byte address, address bit 8 travels in the opcode. A one-cycle completion pulse reports a result code and the number of bytes that completed.

Top module: `nvm_burst_writer`

## Requirements
- R1: For each write chunk the commands are issued in this order: opcode 0x06 with zero address bytes and zero length, then the write opcode (0x02) with the chunk address, then one or more status polls, then the read opcode (0x03) with the same address and length. The data then lands in the device.
- R2: A write chunk's length is the smallest of three values: the bytes remaining, 16, and 2^cfg_blk_log2 minus (address AND (2^cfg_blk_log2 − 1)). So a write command never spans two write blocks.
- R3: A status poll is opcode 0x05 with zero address bytes and a length of 1. The part is ready when bit 0 of the first returned byte is 0. At least POLL_WAIT cycles pass before each poll is issued.
- R4: After POLL_TRIES polls that all report busy, the request ends with result 2 (timeout). No read-back is issued, and the count excludes that chunk.
- R5: When cfg_size_log2 is 9 and cfg_addr_bytes is 1, bit 3 of every read and write opcode equals bit 8 of that command's address (0x02 becomes 0x0A, 0x03 becomes 0x0B). For any other configuration the opcodes are sent unchanged.
- R6: If any read-back byte differs from the byte written, the request ends with result 3 (mismatch). The count covers only the chunks verified before it.
- R7: In read mode (rd_mode = 1) the sequencer issues only opcode 0x03, with lengths of min(remaining, 16) and no block alignment. Byte i of the request is written to buffer index i, and on success the count equals the request length.
- R8: A command that completes with cmd_err ends the request at once with result 1. No further command is issued, and the count covers the chunks completed before it.
- R9: done is high for exactly one cycle, and busy is low in the cycle after done. Result codes are 0 for success, 1 for engine error, 2 for timeout and 3 for mismatch. A zero-length request completes within two cycles with result 0, a count of 0, and no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted when idle |
| rd_mode | input | 1 | 1 = read request, 0 = program-and-verify request |
| req_addr | input | AW | Device start address |
| req_len | input | LW | Request byte count |
| cfg_size_log2 | input | 5 | log2 of the device size in bytes |
| cfg_addr_bytes | input | 2 | Address bytes the part uses |
| cfg_blk_log2 | input | 5 | log2 of the device write-block size |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| done_result | output | 2 | Result code, valid with done |
| done_count | output | LW | Completed bytes, valid with done |
| buf_idx | output | LW | Buffer byte index (relative to the request) |
| buf_rdata | input | 8 | Buffer byte at buf_idx, combinational |
| buf_we | output | 1 | Buffer write strobe (read mode) |
| buf_wdata | output | 8 | Byte to store at buf_idx |
| cmd_go | output | 1 | Command issue pulse to the engine |
| cmd_op | output | 8 | Command opcode |
| cmd_addr | output | AW | Command address |
| cmd_addr_bytes | output | 2 | Address bytes to send (0 = none) |
| cmd_len | output | CLW | Data bytes to transfer |
| cmd_wdata | output | 8*MAXB | Outgoing bytes, byte i in bits 8i+7:8i |
| cmd_rdata | input | 8*MAXB | Returned bytes, valid with cmd_done |
| cmd_done | input | 1 | Engine completion pulse |
| cmd_err | input | 1 | Engine error, qualifies cmd_done |

## Verification
The assertions assume the engine raises cmd_done only for a command already issued, and never in the same cycle as cmd_go. They also assume the three configuration inputs stay constant while busy is high. The bench's engine model meets both: it answers a fixed number of cycles after each issue, and it changes configuration only between requests, at the falling clock edge. With that given, the properties check four things. Commands never overlap. Write commands stay inside one block. Polls carry one byte and no address. The fold bit follows address bit 8.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

    localparam logic [7:0] OP_SET_WEL = 8'h06;
    localparam logic [7:0] OP_PROGRAM = 8'h02;
    localparam logic [7:0] OP_FETCH   = 8'h03;
    localparam logic [7:0] OP_STATUS  = 8'h05;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PLAN,
        ST_LOAD,
        ST_WEL,
        ST_PROG,
        ST_GAP,
        ST_POLL,
        ST_CHECK,
        ST_FETCH,
        ST_STORE,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        RES_OK       = 2'd0,
        RES_ENGINE   = 2'd1,
        RES_TIMEOUT  = 2'd2,
        RES_MISMATCH = 2'd3
    } seq_result_e;

endpackage

// File: rtl/nvm_chunk_sizer.sv
// Picks the length of the next transfer from the remaining count, the
// engine limit and, when alignment is on, the room left in the write block.
module nvm_chunk_sizer #(
    parameter int AW   = 24,
    parameter int LW   = 16,
    parameter int MAXB = 16,
    localparam int CLW = $clog2(MAXB + 1)
) (
    input  logic [AW-1:0]  cur_addr,
    input  logic [LW-1:0]  remaining,
    input  logic [4:0]     blk_log2,
    input  logic           align_en,
    output logic [CLW-1:0] chunk_len
);
    logic [31:0] blk_w;
    logic [31:0] room_w;

    assign blk_w  = 32'd1 << blk_log2;
    assign room_w = blk_w - (32'(cur_addr) & (blk_w - 32'd1));

    always_comb begin
        chunk_len = CLW'(MAXB);
        if (align_en && (room_w < 32'(MAXB))) begin
            chunk_len = room_w[CLW-1:0];
        end
        if (32'(remaining) < 32'(chunk_len)) begin
            chunk_len = remaining[CLW-1:0];
        end
    end
endmodule

// File: rtl/nvm_poll_pacer.sv
// Spaces status polls by WAIT_CYC cycles and counts attempts per chunk.
module nvm_poll_pacer #(
    parameter int WAIT_CYC = 4000,
    parameter int TRIES    = 50,
    localparam int CW = $clog2(WAIT_CYC + 1),
    localparam int TW = $clog2(TRIES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic arm,
    output logic expired,
    output logic out_of_tries
);
    typedef struct packed {
        logic          running;
        logic [CW-1:0] timer;
        logic [TW-1:0] tries;
    } pace_t;

    pace_t pq_d, pq_q;

    always_comb begin
        pq_d = pq_q;
        if (pq_q.running) begin
            if (pq_q.timer == '0) begin
                pq_d.running = 1'b0;
            end else begin
                pq_d.timer = pq_q.timer - 1'b1;
            end
        end
        if (restart) begin
            pq_d.tries = '0;
        end
        if (arm) begin
            pq_d.running = 1'b1;
            pq_d.timer   = CW'(WAIT_CYC - 1);
            pq_d.tries   = pq_q.tries + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pq_q <= '0;
        end else begin
            pq_q <= pq_d;
        end
    end

    assign expired      = pq_q.running && (pq_q.timer == '0);
    assign out_of_tries = (pq_q.tries == TW'(TRIES));

    // R4: attempts never pass the limit
    assert_tries_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pq_q.tries <= TW'(TRIES));

    // R3: a new wait never starts while one is running
    assert_arm_when_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> !pq_q.running);
endmodule

// File: rtl/nvm_burst_writer.sv
module nvm_burst_writer
    import nvm_seq_pkg::*;
#(
    parameter int AW         = 24,
    parameter int LW         = 16,
    parameter int MAXB       = 16,
    parameter int POLL_WAIT  = 4000,
    parameter int POLL_TRIES = 50,
    localparam int CLW = $clog2(MAXB + 1),
    localparam int DW  = 8 * MAXB
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           rd_mode,
    input  logic [AW-1:0]  req_addr,
    input  logic [LW-1:0]  req_len,
    input  logic [4:0]     cfg_size_log2,
    input  logic [1:0]     cfg_addr_bytes,
    input  logic [4:0]     cfg_blk_log2,
    output logic           busy,
    output logic           done,
    output logic [1:0]     done_result,
    output logic [LW-1:0]  done_count,
    output logic [LW-1:0]  buf_idx,
    input  logic [7:0]     buf_rdata,
    output logic           buf_we,
    output logic [7:0]     buf_wdata,
    output logic           cmd_go,
    output logic [7:0]     cmd_op,
    output logic [AW-1:0]  cmd_addr,
    output logic [1:0]     cmd_addr_bytes,
    output logic [CLW-1:0] cmd_len,
    output logic [DW-1:0]  cmd_wdata,
    input  logic [DW-1:0]  cmd_rdata,
    input  logic           cmd_done,
    input  logic           cmd_err
);
    typedef struct packed {
        seq_state_e    st;
        logic          mode;
        logic [AW-1:0] base;
        logic [LW-1:0] total;
        logic [LW-1:0] pos;
        logic [CLW-1:0] clen;
        logic [CLW-1:0] k;
        logic          issued;
        seq_result_e   res;
        logic [DW-1:0] bytes;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [AW-1:0]  cur_addr;
    logic [CLW-1:0] sized_len;
    logic           fold_a8;
    logic [7:0]     fold_bits;
    logic           resp;
    logic           mism;
    logic           pace_arm, pace_restart, pace_expired, pace_spent;
    logic           last_byte;

    assign cur_addr  = ctx_q.base + AW'(ctx_q.pos);
    assign fold_a8   = (cfg_size_log2 == 5'd9) && (cfg_addr_bytes == 2'd1);
    assign fold_bits = {4'b0000, fold_a8 & cur_addr[8], 3'b000};
    assign resp      = ctx_q.issued && cmd_done;
    assign last_byte = (ctx_q.k == ctx_q.clen - 1'b1);

    nvm_chunk_sizer #(.AW(AW), .LW(LW), .MAXB(MAXB)) u_sizer (
        .cur_addr  (cur_addr),
        .remaining (ctx_q.total - ctx_q.pos),
        .blk_log2  (cfg_blk_log2),
        .align_en  (!ctx_q.mode),
        .chunk_len (sized_len)
    );

    nvm_poll_pacer #(.WAIT_CYC(POLL_WAIT), .TRIES(POLL_TRIES)) u_pacer (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (pace_restart),
        .arm          (pace_arm),
        .expired      (pace_expired),
        .out_of_tries (pace_spent)
    );

    // read-back comparison over the live part of the chunk
    always_comb begin
        mism = 1'b0;
        for (int i = 0; i < MAXB; i++) begin
            if ((CLW'(i) < ctx_q.clen) &&
                (cmd_rdata[i*8 +: 8] != ctx_q.bytes[i*8 +: 8])) begin
                mism = 1'b1;
            end
        end
    end

    // command presentation, Moore outputs of the sequencer state
    always_comb begin
        cmd_go         = 1'b0;
        cmd_op         = 8'h00;
        cmd_addr       = '0;
        cmd_addr_bytes = 2'd0;
        cmd_len        = '0;
        unique case (ctx_q.st)
            ST_WEL: begin
                cmd_go = !ctx_q.issued;
                cmd_op = OP_SET_WEL;
            end
            ST_PROG: begin
                cmd_go         = !ctx_q.issued;
                cmd_op         = OP_PROGRAM | fold_bits;
                cmd_addr       = cur_addr;
                cmd_addr_bytes = cfg_addr_bytes;
                cmd_len        = ctx_q.clen;
            end
            ST_POLL: begin
                cmd_go  = !ctx_q.issued;
                cmd_op  = OP_STATUS;
                cmd_len = CLW'(1);
            end
            ST_CHECK, ST_FETCH: begin
                cmd_go         = !ctx_q.issued;
                cmd_op         = OP_FETCH | fold_bits;
                cmd_addr       = cur_addr;
                cmd_addr_bytes = cfg_addr_bytes;
                cmd_len        = ctx_q.clen;
            end
            default: ;
        endcase
    end

    assign pace_restart = (ctx_q.st == ST_PLAN);
    assign pace_arm = resp && !cmd_err &&
                      ((ctx_q.st == ST_PROG) ||
                       ((ctx_q.st == ST_POLL) && cmd_rdata[0] && !pace_spent));

    // next-state computation
    always_comb begin
        ctx_d = ctx_q;
        if (cmd_go) begin
            ctx_d.issued = 1'b1;
        end
        if (resp) begin
            ctx_d.issued = 1'b0;
        end
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctx_d.mode  = rd_mode;
                    ctx_d.base  = req_addr;
                    ctx_d.total = req_len;
                    ctx_d.pos   = '0;
                    ctx_d.res   = RES_OK;
                    ctx_d.st    = ST_PLAN;
                end
            end
            ST_PLAN: begin
                if (ctx_q.pos == ctx_q.total) begin
                    ctx_d.st = ST_DONE;
                end else begin
                    ctx_d.clen = sized_len;
                    ctx_d.k    = '0;
                    ctx_d.st   = ctx_q.mode ? ST_FETCH : ST_LOAD;
                end
            end
            ST_LOAD: begin
                ctx_d.bytes[{ctx_q.k, 3'b000} +: 8] = buf_rdata;
                if (last_byte) begin
                    ctx_d.st = ST_WEL;
                end else begin
                    ctx_d.k = ctx_q.k + 1'b1;
                end
            end
            ST_WEL, ST_PROG, ST_POLL, ST_CHECK, ST_FETCH: begin
                if (resp && cmd_err) begin
                    ctx_d.res = RES_ENGINE;
                    ctx_d.st  = ST_DONE;
                end else if (resp) begin
                    unique case (ctx_q.st)
                        ST_WEL:  ctx_d.st = ST_PROG;
                        ST_PROG: ctx_d.st = ST_GAP;
                        ST_POLL: begin
                            if (!cmd_rdata[0]) begin
                                ctx_d.st = ST_CHECK;
                            end else if (pace_spent) begin
                                ctx_d.res = RES_TIMEOUT;
                                ctx_d.st  = ST_DONE;
                            end else begin
                                ctx_d.st = ST_GAP;
                            end
                        end
                        ST_CHECK: begin
                            if (mism) begin
                                ctx_d.res = RES_MISMATCH;
                                ctx_d.st  = ST_DONE;
                            end else begin
                                ctx_d.pos = ctx_q.pos + LW'(ctx_q.clen);
                                ctx_d.st  = ST_PLAN;
                            end
                        end
                        default: begin
                            ctx_d.bytes = cmd_rdata;
                            ctx_d.k     = '0;
                            ctx_d.st    = ST_STORE;
                        end
                    endcase
                end
            end
            ST_GAP: begin
                if (pace_expired) begin
                    ctx_d.st = ST_POLL;
                end
            end
            ST_STORE: begin
                if (last_byte) begin
                    ctx_d.pos = ctx_q.pos + LW'(ctx_q.clen);
                    ctx_d.st  = ST_PLAN;
                end else begin
                    ctx_d.k = ctx_q.k + 1'b1;
                end
            end
            default: begin
                ctx_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign busy        = (ctx_q.st != ST_IDLE);
    assign done        = (ctx_q.st == ST_DONE);
    assign done_result = ctx_q.res;
    assign done_count  = ctx_q.pos;
    assign buf_idx     = ctx_q.pos + LW'(ctx_q.k);
    assign buf_we      = (ctx_q.st == ST_STORE);
    assign buf_wdata   = ctx_q.bytes[{ctx_q.k, 3'b000} +: 8];
    assign cmd_wdata   = ctx_q.bytes;

    // R1: one command outstanding at a time
    assert_single_issue_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |=> !cmd_go);

    // R2: a program command stays inside one write block and the engine limit
    assert_block_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && ((cmd_op & 8'hF7) == 8'h02)) |->
        ((cmd_len != '0) && (32'(cmd_len) <= 32'(MAXB)) &&
         (((32'(cmd_addr) & ((32'd1 << cfg_blk_log2) - 32'd1)) + 32'(cmd_len))
          <= (32'd1 << cfg_blk_log2))));

    // R3: status polls carry no address and one data byte
    assert_poll_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && (cmd_op == 8'h05)) |-> ((cmd_len == CLW'(1)) && (cmd_addr_bytes == 2'd0)));

    // R5: on small parts the opcode carries address bit 8
    assert_fold_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && (cmd_addr_bytes != 2'd0) && (cfg_size_log2 == 5'd9) &&
         (cfg_addr_bytes == 2'd1)) |-> (cmd_op[3] == cmd_addr[8]));

    // R6: reported count never exceeds the request
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_count <= ctx_q.total));

    // R9: completion is a single pulse followed by idle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9: nothing is driven while idle
    assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cmd_go && !buf_we));
endmodule

// File: tb/nvm_burst_writer_bench.sv
`timescale 1ns/1ps
module nvm_burst_writer_bench;
    localparam int AW = 24;
    localparam int LW = 16;
    localparam int MAXB = 16;
    localparam int PW = 6;
    localparam int PT = 50;
    localparam int CLW = $clog2(MAXB + 1);
    localparam int DW = 8 * MAXB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, rd_mode = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic [4:0] cfg_size_log2 = 5'd13;
    logic [1:0] cfg_addr_bytes = 2'd2;
    logic [4:0] cfg_blk_log2 = 5'd3;
    logic busy, done, buf_we, cmd_go;
    logic [1:0] done_result;
    logic [LW-1:0] done_count, buf_idx;
    logic [7:0] buf_rdata, buf_wdata, cmd_op;
    logic [AW-1:0] cmd_addr;
    logic [1:0] cmd_addr_bytes;
    logic [CLW-1:0] cmd_len;
    logic [DW-1:0] cmd_wdata;
    logic [DW-1:0] cmd_rdata;
    logic cmd_done, cmd_err;

    always #2.5 clk = ~clk;

    nvm_burst_writer #(.AW(AW), .LW(LW), .MAXB(MAXB), .POLL_WAIT(PW), .POLL_TRIES(PT)) u_nvm_burst_writer (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_mode(rd_mode),
        .req_addr(req_addr), .req_len(req_len), .cfg_size_log2(cfg_size_log2),
        .cfg_addr_bytes(cfg_addr_bytes), .cfg_blk_log2(cfg_blk_log2),
        .busy(busy), .done(done), .done_result(done_result), .done_count(done_count),
        .buf_idx(buf_idx), .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_wdata(buf_wdata),
        .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_addr_bytes(cmd_addr_bytes),
        .cmd_len(cmd_len), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .cmd_done(cmd_done), .cmd_err(cmd_err));

    // caller buffers
    logic [7:0] wbuf [0:255];
    logic [7:0] rbuf [0:255];
    assign buf_rdata = wbuf[buf_idx[7:0]];
    always @(posedge clk) if (buf_we) rbuf[buf_idx[7:0]] <= buf_wdata;

    // engine model with command log
    logic [7:0] mem [0:2047];
    logic [7:0] log_op [0:255];
    int log_addr [0:255];
    int log_len [0:255];
    int log_ab [0:255];
    int log_cyc [0:255];
    int nlog, cyc, cnt, busy_left, eff;
    logic pend_err, log_clr = 1'b0;
    int busy_polls = 0, err_idx = 999, corrupt_idx = 999;

    always @(posedge clk) cyc <= cyc + 1;
    initial cyc = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2048; i++) mem[i] <= 8'h00;
            cnt <= 0; cmd_done <= 1'b0; cmd_err <= 1'b0; nlog <= 0;
            busy_left <= 0; pend_err <= 1'b0; cmd_rdata <= '0;
        end else begin
            cmd_done <= 1'b0;
            cmd_err <= 1'b0;
            if (log_clr) nlog <= 0;
            if (cnt != 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) begin
                    cmd_done <= 1'b1;
                    cmd_err <= pend_err;
                end
            end
            if (cmd_go) begin
                if (nlog < 256) begin
                    log_op[nlog] <= cmd_op;
                    log_addr[nlog] <= int'(cmd_addr);
                    log_len[nlog] <= int'(cmd_len);
                    log_ab[nlog] <= int'(cmd_addr_bytes);
                    log_cyc[nlog] <= cyc;
                end
                nlog <= nlog + 1;
                cnt <= 2;
                pend_err <= (nlog == err_idx);
                if (cfg_addr_bytes == 2'd1) eff = {cmd_op[3], cmd_addr[7:0]};
                else eff = int'(cmd_addr);
                case (cmd_op & 8'hF7)
                    8'h02: begin
                        for (int i = 0; i < MAXB; i++)
                            if (i < int'(cmd_len)) mem[(eff + i) & 2047] <= cmd_wdata[i*8 +: 8];
                        busy_left <= busy_polls;
                    end
                    8'h03: begin
                        for (int i = 0; i < MAXB; i++)
                            cmd_rdata[i*8 +: 8] <= (i < int'(cmd_len)) ?
                                (mem[(eff + i) & 2047] ^ (((nlog == corrupt_idx) && (i == 0)) ? 8'hFF : 8'h00)) : 8'h00;
                    end
                    8'h05: begin
                        cmd_rdata <= '0;
                        cmd_rdata[0] <= (busy_left != 0);
                        if (busy_left != 0) busy_left <= busy_left - 1;
                    end
                    default: cmd_rdata <= '0;
                endcase
            end
        end
    end

    int nchk = 0, nfail = 0;
    logic [7:0] exp_mem [0:2047];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_req(input bit rd, input int a, input int n, input int blk, input int sz,
                           input int ab, output int res, output int cnt_o, output bit pulse_ok,
                           output int lat);
        @(negedge clk);
        rd_mode = rd; req_addr = AW'(a); req_len = LW'(n);
        cfg_blk_log2 = 5'(blk); cfg_size_log2 = 5'(sz); cfg_addr_bytes = 2'(ab);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        res = -1; cnt_o = -1; lat = -1;
        for (int t = 0; t < 5000; t++) begin
            if (done) begin
                res = int'(done_result); cnt_o = int'(done_count); lat = t + 1;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        pulse_ok = !done && !busy;
    endtask

    typedef struct packed {
        logic [15:0] a;
        logic [7:0]  n;
        logic [4:0]  blk;
        logic [3:0]  chunks;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{16'h0000, 8'd8,  5'd3, 4'd1},
        '{16'h0005, 8'd20, 5'd3, 4'd4},
        '{16'h001C, 8'd40, 5'd5, 4'd4},
        '{16'h00F8, 8'd30, 5'd8, 4'd3}
    };

    bit finished = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int res, cnt_r, lat, wr, n05;
        bit pok, okb, okm;
        for (int i = 0; i < 2048; i++) exp_mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        check(!busy && !done && !cmd_go && !buf_we, "R9 reset state", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: block-clipped program-and-verify
        for (int v = 0; v < 4; v++) begin
            for (int i = 0; i < 256; i++) wbuf[i] = 8'(v * 37 + i * 7 + 1);
            busy_polls = 1;
            run_req(1'b0, int'(VECS[v].a), int'(VECS[v].n), int'(VECS[v].blk), 13, 2, res, cnt_r, pok, lat);
            check(res == 0 && cnt_r == int'(VECS[v].n), "R1 result/count", cnt_r, int'(VECS[v].n));
            check(pok, "R9 single done pulse", int'(pok), 1);
            wr = 0; okb = 1'b1;
            for (int j = 0; j < nlog; j++) begin
                if (log_op[j] == 8'h02) begin
                    wr++;
                    if (log_len[j] > MAXB || log_len[j] == 0 ||
                        ((log_addr[j] & ((1 << VECS[v].blk) - 1)) + log_len[j]) > (1 << VECS[v].blk))
                        okb = 1'b0;
                end
            end
            check(wr == int'(VECS[v].chunks), "R2 chunk count (unfolded opcode R5)", wr, int'(VECS[v].chunks));
            check(okb, "R2 chunk bounds", int'(okb), 1);
            okm = 1'b1;
            for (int i = 0; i < int'(VECS[v].n); i++) begin
                if (mem[int'(VECS[v].a) + i] != wbuf[i]) okm = 1'b0;
                exp_mem[int'(VECS[v].a) + i] = wbuf[i];
            end
            check(okm, "R1 device contents", int'(okm), 1);
        end

        // read mode, no block alignment
        busy_polls = 0;
        run_req(1'b1, 5, 40, 3, 13, 2, res, cnt_r, pok, lat);
        check(res == 0 && cnt_r == 40, "R7 read count", cnt_r, 40);
        check(nlog == 3, "R7 read command count", nlog, 3);
        check(log_op[0] == 8'h03 && log_op[1] == 8'h03 && log_op[2] == 8'h03, "R7 read opcodes", int'(log_op[1]), 3);
        check(log_len[0] == 16 && log_len[1] == 16 && log_len[2] == 8, "R7 read lengths", log_len[2], 8);
        check(log_addr[1] == 5 + 16 && log_addr[2] == 5 + 32, "R7 read addresses", log_addr[2], 37);
        okm = 1'b1;
        for (int i = 0; i < 40; i++) if (rbuf[i] != exp_mem[5 + i]) okm = 1'b0;
        check(okm, "R7 buffer contents", int'(okm), 1);

        // full command order for one chunk with two busy polls
        for (int i = 0; i < 256; i++) wbuf[i] = 8'(200 - i);
        busy_polls = 2;
        run_req(1'b0, 'h40, 4, 3, 13, 2, res, cnt_r, pok, lat);
        check(res == 0 && cnt_r == 4, "R1 single chunk result", cnt_r, 4);
        check(nlog == 6, "R1 command count", nlog, 6);
        check(log_op[0] == 8'h06 && log_len[0] == 0 && log_ab[0] == 0, "R1 write enable first", int'(log_op[0]), 6);
        check(log_op[1] == 8'h02 && log_addr[1] == 'h40 && log_len[1] == 4 && log_ab[1] == 2, "R1 program step", int'(log_op[1]), 2);
        check(log_op[2] == 8'h05 && log_op[3] == 8'h05 && log_op[4] == 8'h05 &&
              log_len[3] == 1 && log_ab[3] == 0, "R3 status poll shape", int'(log_op[3]), 5);
        check(log_op[5] == 8'h03 && log_addr[5] == 'h40 && log_len[5] == 4, "R1 verify read", int'(log_op[5]), 3);
        check(log_cyc[3] - log_cyc[2] >= PW && log_cyc[2] - log_cyc[1] >= PW, "R3 poll spacing",
              log_cyc[3] - log_cyc[2], PW);

        // 512-byte part, address bit 8 folded into opcode
        busy_polls = 0;
        run_req(1'b0, 'hFC, 8, 3, 9, 1, res, cnt_r, pok, lat);
        check(res == 0 && cnt_r == 8, "R5 folded write result", cnt_r, 8);
        check(log_op[1] == 8'h02 && log_op[3] == 8'h03, "R5 low-half opcodes", int'(log_op[1]), 2);
        check(log_op[5] == 8'h0A && log_op[7] == 8'h0B, "R5 high-half opcodes", int'(log_op[5]), 10);
        check(mem['h100] == wbuf[4] && mem['h103] == wbuf[7], "R5 high-half contents", int'(mem['h100]), int'(wbuf[4]));

        // verify mismatch on the second chunk
        corrupt_idx = 7;
        run_req(1'b0, 'h80, 16, 3, 13, 2, res, cnt_r, pok, lat);
        corrupt_idx = 999;
        check(res == 3, "R6 mismatch code", res, 3);
        check(cnt_r == 8, "R6 mismatch count", cnt_r, 8);

        // engine error on the second program command
        err_idx = 5;
        run_req(1'b0, 'h80, 16, 3, 13, 2, res, cnt_r, pok, lat);
        repeat (20) @(negedge clk);
        check(res == 1 && cnt_r == 8, "R8 write error result", cnt_r, 8);
        check(nlog == 6, "R8 no command after error", nlog, 6);

        // engine error on the second read
        err_idx = 1;
        run_req(1'b1, 0, 40, 3, 13, 2, res, cnt_r, pok, lat);
        err_idx = 999;
        check(res == 1 && cnt_r == 16, "R8 read error count (R7)", cnt_r, 16);

        // poll timeout
        busy_polls = 1000;
        run_req(1'b0, 0, 8, 3, 13, 2, res, cnt_r, pok, lat);
        n05 = 0;
        for (int j = 0; j < nlog; j++) if (log_op[j] == 8'h05) n05++;
        check(res == 2 && cnt_r == 0, "R4 timeout result", res, 2);
        check(n05 == PT, "R4 poll attempts", n05, PT);
        check(nlog == PT + 2, "R4 no verify after timeout", nlog, PT + 2);
        busy_polls = 0;

        // zero-length request
        run_req(1'b0, 'h10, 0, 3, 13, 2, res, cnt_r, pok, lat);
        check(res == 0 && cnt_r == 0 && nlog == 0, "R9 zero length", nlog, 0);
        check(lat >= 1 && lat <= 2, "R9 zero length latency", lat, 2);
        check(pok, "R9 done pulse width", int'(pok), 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule